// File: doc/BRIEF.md
# Bit-Reversed Strided Load Address Sequencer

This block turns one vector-load request into a stream of per-element effective addresses, where each element's position in memory is found by reversing the bits of its index before scaling it. That ordering is the data shuffle that feeds one pass of a radix-2 FFT or DCT butterfly. The caller presents the base value, a flag saying the base register is number zero, a signed displacement, an element-size code, a shift amount and a power-of-two vector length, together with a one-cycle start pulse. The block captures these operands and then offers one element at a time on a valid/ready interface. Each element carries its plain index and its address.

The controller has three states. IDLE waits for start and goes to RUN when start is seen (transition START). RUN presents the current element. It stays in RUN while ready is low (STALL) or after a non-final element is taken (ADVANCE), and it goes to DONE after the final element is taken (FINISH). DONE raises the done flag for exactly one cycle and then returns to IDLE (RETIRE). The address for element i is the base term plus the product of the sign-extended displacement, the element size in bytes and the reversed index, with that product shifted left by the shift amount. All arithmetic is 64-bit and wraps. Memory access, writeback and data conversion are left to neighbouring logic.

Top module: `bitrev_ldaddr_gen`

## Requirements
- R1: After reset, valid_o and done_o are 0 and idx_o is 0.
- R2: After a start pulse in IDLE, valid_o rises in the next cycle with idx_o = 0. Each accepted handshake (valid_o and ready_i both high at a clock edge) advances idx_o by one, through VL-1.
- R3: The reversed index is idx_o with its low log2(VL) bits in reverse order. For VL=4 the reversed values of indices 0,1,2,3 are 0,2,1,3. For VL=1 the reversed value is always 0. vl_i is one of 1, 2, 4, 8, 16, 32 or 64.
- R4: addr_o = base + ((signext64(disp_i) * bytes * rev) << rc), modulo 2^64. The byte count comes from esize_i: 0 gives 1, 1 gives 2, 2 gives 4 and 3 gives 8.
- R5: rc_i (0 to 63) shifts the scaled offset left before it is added to the base. rc_i = 0 gives the plain reversed stride.
- R6: When base_is_r0_i is 1, the base term is 0 whatever base_i holds.
- R7: While valid_o is 1 and ready_i is 0, valid_o, idx_o and addr_o hold their values into the next cycle.
- R8: done_o is 1 for exactly the one cycle after the final element is accepted, and valid_o is 0 in that cycle.
- R9: A start pulse is ignored in RUN and in DONE. The element sequence keeps the operands captured at the accepted start, and no new sequence begins.
- R10: A negative displacement gives addresses below the base, wrapping through zero when needed. For example, base 0, disp -1, 1-byte elements and VL=2 give element 1 at address 0xFFFF_FFFF_FFFF_FFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request pulse, sampled in IDLE only |
| base_i | input | 64 | Base register value |
| base_is_r0_i | input | 1 | Base register is number zero, so the base term is 0 |
| disp_i | input | 16 | Signed displacement |
| esize_i | input | 2 | Element-size code (1, 2, 4 or 8 bytes) |
| rc_i | input | 6 | Left shift applied to the scaled offset |
| vl_i | input | 7 | Vector length, a power of two from 1 to 64 |
| ready_i | input | 1 | Consumer accepts the current element |
| valid_o | output | 1 | An element is presented |
| idx_o | output | 6 | Plain element index |
| addr_o | output | 64 | Effective address of the element |
| done_o | output | 1 | One-cycle pulse after the final element |

## Verification
The hardest case to reach from the ports is a second request arriving while a sequence is still in flight. This includes the single DONE cycle, when the controller is about to return to IDLE and would accept a request one cycle later. The stimulus halts a sequence with ready low and pulses start with entirely different operands. It then pulses start again on the exact cycle done is high. The bench confirms that the remaining addresses still follow the first operand set and that valid stays low after DONE. Backpressure holding is reached by stalling chosen elements for one cycle and comparing the held outputs against the same expected address.

// File: rtl/bragu_pkg.sv
package bragu_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } seq_state_t;

    typedef enum logic [1:0] {
        ES_BYTE  = 2'd0,
        ES_HALF  = 2'd1,
        ES_WORD  = 2'd2,
        ES_DWORD = 2'd3
    } esize_t;
endpackage

// File: rtl/bitrev_idx.sv
module bitrev_idx #(
    parameter int IW  = 6,
    parameter int LW  = 3
) (
    input  logic [IW-1:0] idx_i,
    input  logic [LW-1:0] len_i,
    output logic [IW-1:0] rev_o
);
    localparam logic [LW-1:0] FULL_LEN = LW'(IW);

    logic [IW-1:0] full_rev;

    generate
        for (genvar b = 0; b < IW; b++) begin : g_mirror
            assign full_rev[IW-1-b] = idx_i[b];
        end
    endgenerate

    // Reverse all IW bits, then drop the positions above len_i.
    assign rev_o = full_rev >> (FULL_LEN - len_i);
endmodule

// File: rtl/elem_offset.sv
module elem_offset #(
    parameter int AW  = 64,
    parameter int DW  = 16,
    parameter int IW  = 6,
    parameter int RCW = 6
) (
    input  logic [AW-1:0]  base_i,
    input  logic           base_zero_i,
    input  logic [DW-1:0]  disp_i,
    input  logic [1:0]     esize_i,
    input  logic [RCW-1:0] rc_i,
    input  logic [IW-1:0]  rev_i,
    output logic [AW-1:0]  addr_o
);
    logic [AW-1:0] disp_ext;
    logic [AW-1:0] scaled;
    logic [AW-1:0] product;
    logic [AW-1:0] spread;
    logic [AW-1:0] base_term;

    always_comb begin
        disp_ext  = {{(AW-DW){disp_i[DW-1]}}, disp_i};
        scaled    = disp_ext << esize_i;
        product   = scaled * {{(AW-IW){1'b0}}, rev_i};
        spread    = product << rc_i;
        base_term = base_zero_i ? '0 : base_i;
        addr_o    = base_term + spread;
    end
endmodule

// File: rtl/bitrev_ldaddr_gen.sv
module bitrev_ldaddr_gen
    import bragu_pkg::*;
#(
    parameter int AW     = 64,
    parameter int DW     = 16,
    parameter int MAX_LG = 6,
    parameter int RCW    = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [AW-1:0]     base_i,
    input  logic              base_is_r0_i,
    input  logic [DW-1:0]     disp_i,
    input  logic [1:0]        esize_i,
    input  logic [RCW-1:0]    rc_i,
    input  logic [MAX_LG:0]   vl_i,
    input  logic              ready_i,
    output logic              valid_o,
    output logic [MAX_LG-1:0] idx_o,
    output logic [AW-1:0]     addr_o,
    output logic              done_o
);
    localparam int IW = MAX_LG;
    localparam int LW = $clog2(MAX_LG + 1);

    seq_state_t state_q, state_d;

    logic [AW-1:0]  base_q;
    logic           bzero_q;
    logic [DW-1:0]  disp_q;
    logic [1:0]     esize_q;
    logic [RCW-1:0] rc_q;
    logic [LW-1:0]  len_q;
    logic [IW-1:0]  idx_q;
    logic [IW-1:0]  last_idx;
    logic [IW-1:0]  rev_idx;
    logic           take;
    logic           at_last;

    function automatic logic [LW-1:0] vl_log2(input logic [MAX_LG:0] vl);
        logic [LW-1:0] l;
        l = '0;
        for (int k = 0; k <= MAX_LG; k++) begin
            if (vl[k]) l = LW'(k);
        end
        return l;
    endfunction

    assign last_idx = (IW'(1) << len_q) - IW'(1);
    assign take     = (state_q == ST_RUN) && ready_i;
    assign at_last  = (idx_q == last_idx);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i) state_d = ST_RUN;        // START
            ST_RUN:  if (ready_i && at_last) state_d = ST_DONE; // FINISH
            ST_DONE: state_d = ST_IDLE;                    // RETIRE
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // operand capture and element counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q  <= '0;
            bzero_q <= 1'b0;
            disp_q  <= '0;
            esize_q <= '0;
            rc_q    <= '0;
            len_q   <= '0;
            idx_q   <= '0;
        end else if (state_q == ST_IDLE && start_i) begin
            base_q  <= base_i;
            bzero_q <= base_is_r0_i;
            disp_q  <= disp_i;
            esize_q <= esize_i;
            rc_q    <= rc_i;
            len_q   <= vl_log2(vl_i);
            idx_q   <= '0;
        end else if (take && !at_last) begin
            idx_q   <= idx_q + IW'(1);                     // ADVANCE
        end
    end

    bitrev_idx #(.IW(IW), .LW(LW)) i_rev (
        .idx_i (idx_q),
        .len_i (len_q),
        .rev_o (rev_idx)
    );

    logic [AW-1:0] addr_calc;

    elem_offset #(.AW(AW), .DW(DW), .IW(IW), .RCW(RCW)) i_off (
        .base_i      (base_q),
        .base_zero_i (bzero_q),
        .disp_i      (disp_q),
        .esize_i     (esize_q),
        .rc_i        (rc_q),
        .rev_i       (rev_idx),
        .addr_o      (addr_calc)
    );

    // outputs
    always_comb begin
        valid_o = 1'b0;
        done_o  = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_RUN:  valid_o = 1'b1;
            ST_DONE: done_o  = 1'b1;
            default: ;
        endcase
        idx_o  = idx_q;
        addr_o = addr_calc;
    end

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o && !ready_i |=> valid_o && $stable(idx_o) && $stable(addr_o)); // R7
    AST_FIRST_IDX: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid_o) |-> idx_o == '0); // R2
    AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o && ready_i && !at_last |=> valid_o && idx_o == $past(idx_o) + IW'(1)); // R2
    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o && ready_i && at_last |=> done_o && !valid_o); // R8
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o && !valid_o); // R8 R9
    AST_HOLD_OPERANDS: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o && $past(valid_o) |-> $stable(base_q) && $stable(disp_q) && $stable(rc_q)); // R9
endmodule

// File: tb/test_bitrev_ldaddr_gen.sv
module test_bitrev_ldaddr_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [63:0] base_i = '0;
    logic        base_is_r0_i = 1'b0;
    logic [15:0] disp_i = '0;
    logic [1:0]  esize_i = '0;
    logic [5:0]  rc_i = '0;
    logic [6:0]  vl_i = 7'd1;
    logic        ready_i = 1'b0;
    logic        valid_o;
    logic [5:0]  idx_o;
    logic [63:0] addr_o;
    logic        done_o;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    bitrev_ldaddr_gen i_bitrev_ldaddr_gen (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_i(base_i),
        .base_is_r0_i(base_is_r0_i), .disp_i(disp_i), .esize_i(esize_i),
        .rc_i(rc_i), .vl_i(vl_i), .ready_i(ready_i), .valid_o(valid_o),
        .idx_o(idx_o), .addr_o(addr_o), .done_o(done_o)
    );

    typedef struct packed {
        logic [63:0] base;
        logic        r0;
        logic [15:0] disp;
        logic [1:0]  es;
        logic [5:0]  rc;
        logic [2:0]  lg;
        logic        stall;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{64'h10,               1'b0, 16'd1,      2'd2, 6'd0, 3'd2, 1'b0}, // R3 VL=4
        '{64'h1000,             1'b0, 16'd8,      2'd3, 6'd0, 3'd3, 1'b1}, // R4 dword
        '{64'hDEAD_0000,        1'b1, 16'd3,      2'd1, 6'd0, 3'd3, 1'b0}, // R6
        '{64'h2000,             1'b0, 16'd4,      2'd2, 6'd3, 3'd4, 1'b1}, // R5
        '{64'h100,              1'b0, 16'hFFFC,   2'd2, 6'd1, 3'd3, 1'b0}, // R10
        '{64'h0,                1'b0, 16'h7FFF,   2'd0, 6'd40, 3'd6, 1'b0},// R4 VL=64
        '{64'h55,               1'b0, 16'd9,      2'd1, 6'd2, 3'd0, 1'b1}  // R3 VL=1
    };

    function automatic logic [63:0] exp_addr(vec_t v, int i);
        logic [63:0] rev;
        logic [63:0] off;
        rev = '0;
        for (int b = 0; b < int'(v.lg); b++) rev[int'(v.lg) - 1 - b] = i[b];
        off = {{48{v.disp[15]}}, v.disp} * (64'd1 << v.es) * rev;
        off = off << v.rc;
        return (v.r0 ? 64'd0 : v.base) + off;
    endfunction

    task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
        end
    endtask

    task automatic load(input vec_t v);
        base_i = v.base; base_is_r0_i = v.r0; disp_i = v.disp;
        esize_i = v.es; rc_i = v.rc; vl_i = 7'(1 << v.lg);
    endtask

    task automatic check_elem(input vec_t v, input int i, input string req);
        chk(valid_o == 1'b1, "R2 valid", 64'(valid_o), 64'd1);
        chk(idx_o == 6'(i), "R2 index", 64'(idx_o), 64'(i));
        chk(addr_o == exp_addr(v, i), req, addr_o, exp_addr(v, i));
    endtask

    // Walk one sequence; mid_start injects a foreign start after element 1.
    task automatic run_seq(input vec_t v, input bit mid_start);
        int n;
        vec_t other;
        n = 1 << v.lg;
        @(negedge clk); load(v); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        for (int i = 0; i < n; i++) begin
            if (v.stall && (i % 2 == 0)) begin
                ready_i = 1'b0;
                @(negedge clk);
                check_elem(v, i, "R7 stall hold");
            end
            if (mid_start && i == 2) begin
                other = '{64'hFFFF_0000, 1'b0, 16'd100, 2'd3, 6'd5, 3'd1, 1'b0};
                load(other); start_i = 1'b1; ready_i = 1'b0;
                @(negedge clk); start_i = 1'b0;
                check_elem(v, i, "R9 start ignored");
            end
            check_elem(v, i, "R4 address");
            ready_i = 1'b1;
            @(negedge clk);
            ready_i = 1'b0;
        end
        chk(done_o == 1'b1, "R8 done raised", 64'(done_o), 64'd1);
        chk(valid_o == 1'b0, "R8 valid low in done", 64'(valid_o), 64'd0);
        start_i = 1'b1; // R9: start during DONE must be ignored
        @(negedge clk);
        start_i = 1'b0;
        chk(done_o == 1'b0, "R8 done one cycle", 64'(done_o), 64'd0);
        @(negedge clk);
        chk(valid_o == 1'b0, "R9 no restart from done", 64'(valid_o), 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(valid_o == 1'b0, "R1 valid", 64'(valid_o), 64'd0);
        chk(done_o == 1'b0, "R1 done", 64'(done_o), 64'd0);
        chk(idx_o == 6'd0, "R1 idx", 64'(idx_o), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int k = 0; k < NV; k++) run_seq(VECS[k], 1'b0);

        // R3 explicit order for VL=4: 0x10, 0x18, 0x14, 0x1c
        begin
            vec_t v;
            v = VECS[0];
            chk(exp_addr(v, 1) == 64'h18, "R3 bench model", exp_addr(v, 1), 64'h18);
            @(negedge clk); load(v); start_i = 1'b1;
            @(negedge clk); start_i = 1'b0; ready_i = 1'b1;
            chk(addr_o == 64'h10, "R3 elem0", addr_o, 64'h10);
            @(negedge clk); chk(addr_o == 64'h18, "R3 elem1", addr_o, 64'h18);
            @(negedge clk); chk(addr_o == 64'h14, "R3 elem2", addr_o, 64'h14);
            @(negedge clk); chk(addr_o == 64'h1c, "R3 elem3", addr_o, 64'h1c);
            @(negedge clk); ready_i = 1'b0;
            chk(done_o == 1'b1, "R8 done after last", 64'(done_o), 64'd1);
            @(negedge clk);
        end

        // R10 wrap below zero
        begin
            vec_t w;
            w = '{64'h0, 1'b0, 16'hFFFF, 2'd0, 6'd0, 3'd1, 1'b0};
            @(negedge clk); load(w); start_i = 1'b1;
            @(negedge clk); start_i = 1'b0; ready_i = 1'b1;
            chk(addr_o == 64'h0, "R10 elem0", addr_o, 64'h0);
            @(negedge clk);
            chk(addr_o == 64'hFFFF_FFFF_FFFF_FFFF, "R10 wrap", addr_o, 64'hFFFF_FFFF_FFFF_FFFF);
            @(negedge clk); ready_i = 1'b0;
            @(negedge clk);
        end

        // R9 start mid-sequence with other operands
        run_seq(VECS[3], 1'b1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=<100000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule